// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the datapath of one DMA channel. Software loads a 16-bit start address, a 16-bit transfer count (one less than the number of transfers wanted) and an 8-bit page value. Every time the bus sequencer completes a transfer it pulses a strobe. The engine then steps the address up, steps the count down and forms the 24-bit physical address that goes on the bus.

The channel runs in one of two flavours. In byte mode the address names bytes inside a 64K window selected by the page. In word mode the address names 16-bit words inside a 128K window, and the low page bit is not used. The page is never incremented, so a run wraps inside its window instead of crossing into the next one.

When the count runs out, the engine raises terminal count for one cycle. It then either masks the channel or, with auto-init set, restores the start address and count from the copies kept at load. A cascade setting stops all addressing, so the channel only forwards requests. A residue output gives the transfers still outstanding, expressed in bytes.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the channel is masked, `tc` is low, `phys_addr` is 0 and `residue_bytes` is 1 (byte mode).
- R2: In byte mode (`word_mode`=0, `cascade`=0), `phys_addr` = {page[7:0], address[15:0]}.
- R3: In word mode (`word_mode`=1, `cascade`=0), `phys_addr` = {page[7:1], address[15:0], 0`b`}, so page bit 0 is ignored and `phys_addr[0]` is always 0.
- R4: Each accepted strobe adds one to the address. The address wraps from 0xFFFF to 0x0000 and the page part of `phys_addr` does not change.
- R5: A loaded count of N-1 gives N accepted strobes before terminal count. `tc` is high for exactly the one cycle after the accepted strobe that finds the count at 0x0000.
- R6: At terminal count with `auto_init`=0, the channel becomes masked, the count becomes 0xFFFF (residue 0) and the address still steps by one.
- R7: At terminal count with `auto_init`=1, the address and count are restored to the values last loaded, and the channel stays unmasked.
- R8: `residue_bytes` = ((count + 1) mod 2^16) in byte mode, and that value shifted left by one (17 bits) in word mode.
- R9: While the channel is masked, strobes change neither the address nor the count.
- R10: With `cascade`=1, `phys_addr` is 0, strobes change no state and `tc` stays low. The state is intact when `cascade` is cleared again.
- R11: `load` writes the address, count and page together with their restore copies, and unmasks the channel. When `load` and a strobe fall in the same cycle, the load wins and no step happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_mode | input | 1 | 1 = word flavour, 0 = byte flavour |
| cascade | input | 1 | 1 = pass-through only, no addressing |
| auto_init | input | 1 | Restore address and count at terminal count |
| load | input | 1 | Load address, count and page |
| load_addr | input | 16 | Start address |
| load_count | input | 16 | Transfer count minus one |
| load_page | input | 8 | Page value |
| xfer_done | input | 1 | One transfer completed |
| phys_addr | output | 24 | Physical bus address |
| tc | output | 1 | Terminal count pulse |
| chan_masked | output | 1 | Channel mask state |
| residue_bytes | output | 17 | Outstanding bytes |

## Verification
Two pairs of events can fall in the same cycle. The first is a load arriving together with a transfer strobe. The bench holds the strobe high through a load and then checks that the loaded address and residue appear unchanged, with no step and no terminal count. The second is terminal count arriving together with the auto-init restore. The bench runs a short count to zero and checks in that same cycle that `tc` is high, that the address and residue are back at their loaded values, and that the channel is still unmasked. A behavioural model is compared against every output on every clock.

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       word_mode,
  input  logic                       cascade,
  input  logic                       auto_init,
  input  logic                       load,
  input  logic [ADDR_W-1:0]          load_addr,
  input  logic [ADDR_W-1:0]          load_count,
  input  logic [PAGE_W-1:0]          load_page,
  input  logic                       xfer_done,
  output logic [PAGE_W+ADDR_W-1:0]   phys_addr,
  output logic                       tc,
  output logic                       chan_masked,
  output logic [ADDR_W:0]            residue_bytes
);
  localparam int PHYS_W = PAGE_W + ADDR_W;

  logic [ADDR_W-1:0] cur_addr, cur_cnt, base_addr, base_cnt;
  logic [PAGE_W-1:0] page_q;
  logic              masked_q, tc_q;

  wire take = xfer_done && !masked_q && !cascade && !load;
  wire last = (cur_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      cur_cnt   <= '0;
      base_addr <= '0;
      base_cnt  <= '0;
      page_q    <= '0;
      masked_q  <= 1'b1;
      tc_q      <= 1'b0;
    end else begin
      tc_q <= take && last;
      if (load) begin
        cur_addr  <= load_addr;
        base_addr <= load_addr;
        cur_cnt   <= load_count;
        base_cnt  <= load_count;
        page_q    <= load_page;
        masked_q  <= 1'b0;
      end else if (take) begin
        if (last && auto_init) begin
          cur_addr <= base_addr;
          cur_cnt  <= base_cnt;
        end else begin
          cur_addr <= cur_addr + ADDR_W'(1);
          cur_cnt  <= cur_cnt - ADDR_W'(1);
          if (last) masked_q <= 1'b1;
        end
      end
    end
  end

  wire [ADDR_W-1:0] left = cur_cnt + ADDR_W'(1);

  assign phys_addr     = cascade   ? '0 :
                         word_mode ? {page_q[PAGE_W-1:1], cur_addr, 1'b0} :
                                     PHYS_W'({page_q, cur_addr});
  assign residue_bytes = word_mode ? {left, 1'b0} : {1'b0, left};
  assign tc            = tc_q;
  assign chan_masked   = masked_q;
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     word_mode,
  input logic                     cascade,
  input logic                     auto_init,
  input logic                     load,
  input logic [ADDR_W-1:0]        load_addr,
  input logic                     xfer_done,
  input logic [PAGE_W+ADDR_W-1:0] phys_addr,
  input logic                     tc,
  input logic                     chan_masked,
  input logic [ADDR_W-1:0]        cur_addr,
  input logic [ADDR_W-1:0]        cur_cnt,
  input logic [ADDR_W-1:0]        base_addr,
  input logic [ADDR_W-1:0]        base_cnt
);
  a_r3_word_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    (word_mode && !cascade) |-> phys_addr[0] == 1'b0);

  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !chan_masked && !cascade && !load && cur_cnt != '0)
      |=> (cur_addr - $past(cur_addr)) == ADDR_W'(1));

  a_r5_tc_source: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> ($past(cur_cnt) == '0 && $past(xfer_done) && !$past(chan_masked)));

  a_r6_mask_on_tc: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !$past(auto_init)) |-> chan_masked);

  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && $past(auto_init)) |-> (cur_addr == base_addr && cur_cnt == base_cnt && !chan_masked));

  a_r9_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_masked && !load) |=> ($stable(cur_addr) && $stable(cur_cnt)));

  a_r10_cascade_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && !load) |=> ($stable(cur_addr) && $stable(cur_cnt) && !tc));

  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur_addr == $past(load_addr) && !chan_masked && !tc));
endmodule

bind dma_chan_engine dma_chan_engine_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .cascade(cascade),
  .auto_init(auto_init), .load(load), .load_addr(load_addr), .xfer_done(xfer_done),
  .phys_addr(phys_addr), .tc(tc), .chan_masked(chan_masked),
  .cur_addr(cur_addr), .cur_cnt(cur_cnt), .base_addr(base_addr), .base_cnt(base_cnt)
);

// File: tb/dma_chan_engine_tb.sv
module dma_chan_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_mode = 1'b0, cascade = 1'b0, auto_init = 1'b0, load = 1'b0, xfer_done = 1'b0;
  logic [15:0] load_addr = '0, load_count = '0;
  logic [7:0]  load_page = '0;
  logic [23:0] phys_addr;
  logic        tc, chan_masked;
  logic [16:0] residue_bytes;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  int m_addr = 0, m_cnt = 0, m_baddr = 0, m_bcnt = 0, m_page = 0, m_mask = 1, m_tc = 0;

  always #2.5 clk = ~clk;

  dma_chan_engine u_dut (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .cascade(cascade),
    .auto_init(auto_init), .load(load), .load_addr(load_addr), .load_count(load_count),
    .load_page(load_page), .xfer_done(xfer_done), .phys_addr(phys_addr), .tc(tc),
    .chan_masked(chan_masked), .residue_bytes(residue_bytes)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_phys();
    if (cascade) return 0;
    if (word_mode) return ((m_page >> 1) << 17) | (m_addr << 1);
    return (m_page << 16) | m_addr;
  endfunction

  function automatic int exp_res();
    int r;
    r = (m_cnt + 1) & 16'hFFFF;
    return word_mode ? (r << 1) : r;
  endfunction

  // behavioural reference, compared every clock
  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = 0; m_cnt = 0; m_baddr = 0; m_bcnt = 0; m_page = 0; m_mask = 1; m_tc = 0;
    end else if (load) begin
      m_addr = load_addr; m_baddr = load_addr; m_cnt = load_count; m_bcnt = load_count;
      m_page = load_page; m_mask = 0; m_tc = 0;
    end else if (xfer_done && m_mask == 0 && !cascade) begin
      if (m_cnt == 0) begin
        m_tc = 1;
        if (auto_init) begin
          m_addr = m_baddr; m_cnt = m_bcnt;
        end else begin
          m_addr = (m_addr + 1) & 16'hFFFF; m_cnt = 16'hFFFF; m_mask = 1;
        end
      end else begin
        m_tc = 0; m_addr = (m_addr + 1) & 16'hFFFF; m_cnt = m_cnt - 1;
      end
    end else m_tc = 0;
    #1;
    if (rst_n && !done) begin
      chk(cascade ? "R10 phys" : (word_mode ? "R3 phys" : "R2 phys"), int'(phys_addr), exp_phys());
      chk("R5 tc", int'(tc), m_tc);
      chk("R6 mask", int'(chan_masked), m_mask);
      chk("R8 residue", int'(residue_bytes), exp_res());
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic ld(input int a, input int c, input int p);
    load_addr = 16'(a); load_count = 16'(c); load_page = 8'(p); load = 1'b1;
    tick();
    load = 1'b0;
  endtask

  task automatic strobe(input int n);
    xfer_done = 1'b1;
    for (int i = 0; i < n; i++) tick();
    xfer_done = 1'b0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 masked", int'(chan_masked), 1);
    chk("R1 tc", int'(tc), 0);
    chk("R1 phys", int'(phys_addr), 0);
    chk("R1 residue", int'(residue_bytes), 1);

    strobe(2);
    chk("R9 residue held", int'(residue_bytes), 1);

    ld(16'hFFFE, 3, 8'h12);
    chk("R2 phys", int'(phys_addr), 24'h12FFFE);
    chk("R11 unmask", int'(chan_masked), 0);
    chk("R8 residue", int'(residue_bytes), 4);
    strobe(1);
    chk("R4 step", int'(phys_addr), 24'h12FFFF);
    strobe(1);
    chk("R4 wrap", int'(phys_addr), 24'h120000);
    strobe(1);
    chk("R5 no early tc", int'(tc), 0);
    strobe(1);
    chk("R5 tc", int'(tc), 1);
    chk("R6 masked", int'(chan_masked), 1);
    chk("R6 residue", int'(residue_bytes), 0);
    tick();
    chk("R5 tc one cycle", int'(tc), 0);
    strobe(2);
    chk("R9 addr held", int'(phys_addr), 24'h120002);

    word_mode = 1'b1;
    ld(16'h1234, 1, 8'h35);
    chk("R3 phys", int'(phys_addr), 24'h342468);
    chk("R8 word residue", int'(residue_bytes), 4);
    strobe(1);
    chk("R3 step", int'(phys_addr), 24'h34246A);
    ld(0, 16'h7FFF, 0);
    chk("R8 word big", int'(residue_bytes), 17'h10000);

    word_mode = 1'b0; auto_init = 1'b1;
    ld(16'h0100, 1, 0);
    strobe(2);
    chk("R7 tc", int'(tc), 1);
    chk("R7 addr", int'(phys_addr), 24'h000100);
    chk("R7 unmasked", int'(chan_masked), 0);
    chk("R7 residue", int'(residue_bytes), 2);
    strobe(1);
    chk("R7 run again", int'(phys_addr), 24'h000101);

    cascade = 1'b1;
    tick();
    chk("R10 phys zero", int'(phys_addr), 0);
    strobe(3);
    chk("R10 tc low", int'(tc), 0);
    cascade = 1'b0;
    tick();
    chk("R10 state kept", int'(phys_addr), 24'h000101);
    chk("R10 residue kept", int'(residue_bytes), 1);

    xfer_done = 1'b1;
    ld(16'h4000, 5, 8'h22);
    xfer_done = 1'b0;
    chk("R11 load wins addr", int'(phys_addr), 24'h224000);
    chk("R11 load wins residue", int'(residue_bytes), 6);

    auto_init = 1'b0;
    ld(16'h0010, 0, 8'h01);
    strobe(1);
    chk("R5 single transfer tc", int'(tc), 1);
    chk("R6 single masked", int'(chan_masked), 1);

    tick();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule